// File: doc/BRIEF.md
# Fractional-Step Sawtooth Generator

This block produces a 12-bit sawtooth output code for one converter channel. A 16-bit accumulator holds the waveform in 12.4 unsigned fixed point; the upper twelve bits are the output code. Two triggers act on the accumulator. A restart trigger loads a configured start code. An advance trigger adds the configured step to the accumulator or subtracts it, as the direction input selects.

Each trigger has its own source select. Code 0 selects a single-cycle software strobe, and code k selects the rising edge of hardware event line k-1. A software strobe aimed at a trigger that is routed to hardware is refused, has no effect and raises an error pulse. The generator runs only while the 2-bit wave-mode input selects sawtooth. The other mode codes belong to generators outside this block.

Top module: `saw_gen`

## Requirements
- R1: After synchronous reset the accumulator is zero, `code_out` reads 0 and `err_pulse` is low.
- R2: The block is active only when `wave_mode` is 2'b11. For any other code (00 off, 01 noise, 10 triangle), `code_out` reads 0 and triggers leave the accumulator unchanged.
- R3: A restart trigger sets the accumulator to {`start_code`, 4'b0000}. The new code appears on `code_out` in the cycle after the trigger.
- R4: With `dir_down`=0 an advance trigger adds `step_val` (12 integer bits above 4 fraction bits) to the accumulator modulo 2^16. `code_out` always shows accumulator bits [15:4].
- R5: With `dir_down`=1 an advance trigger subtracts `step_val` from the accumulator modulo 2^16.
- R6: When restart and advance trigger in the same cycle, the restart wins and no step is applied.
- R7: A select code of 0 takes the software strobe. A code k from 1 to NUM_EVT takes a rising edge on `hw_evt[k-1]`, and an input that stays high triggers only once. A code above NUM_EVT selects no source.
- R8: A software strobe is refused when its trigger's select code is not 0. The accumulator does not change, and `err_pulse` is high for exactly the one cycle after the strobe.
- R9: The restart and advance triggers use independent source selects, so either one can be on hardware while the other is on software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_mode | input | 2 | Wave generator mode; 2'b11 enables this block |
| start_code | input | 12 | Code loaded by a restart trigger |
| step_val | input | 16 | Step size in 12.4 unsigned fixed point |
| dir_down | input | 1 | 1 = advance subtracts, 0 = advance adds |
| restart_sel | input | SEL_W | Source select of the restart trigger |
| advance_sel | input | SEL_W | Source select of the advance trigger |
| sw_restart | input | 1 | Software restart strobe, one cycle |
| sw_advance | input | 1 | Software advance strobe, one cycle |
| hw_evt | input | NUM_EVT | Hardware event lines, rising-edge sensitive |
| code_out | output | 12 | Sawtooth output code |
| err_pulse | output | 1 | One-cycle pulse for a refused software strobe |

## Verification
The hardest situations to reach are those where sources collide. A software strobe can arrive on a trigger that is routed to hardware while a real hardware edge lands in the same cycle. A restart and an advance can also fire together from different sources. The stimulus produces these by setting one trigger's select to an event line and leaving the other on software, then pulsing the event line and both strobes in a single cycle. A sweep of step values in both directions, long enough to wrap past both ends of the 16-bit range, checks every fractional carry against a model in the bench.

// File: rtl/saw_pkg.sv
package saw_pkg;
    localparam int CODE_W = 12;
    localparam int FRAC_W = 4;
    localparam int ACC_W  = CODE_W + FRAC_W;

    typedef enum logic [1:0] {
        WM_OFF   = 2'b00,
        WM_NOISE = 2'b01,
        WM_TRI   = 2'b10,
        WM_SAW   = 2'b11
    } wave_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0] start_code;
        logic [ACC_W-1:0]  step;
        logic              down;
    } saw_cfg_t;

    typedef struct packed {
        logic restart;
        logic advance;
    } saw_fire_t;

    // Next accumulator value for one advance; wraps modulo 2^ACC_W.
    function automatic logic [ACC_W-1:0] advance_acc(input logic [ACC_W-1:0] acc,
                                                     input saw_cfg_t cfg);
        return cfg.down ? (acc - cfg.step) : (acc + cfg.step);
    endfunction

    function automatic logic [ACC_W-1:0] restart_acc(input saw_cfg_t cfg);
        return {cfg.start_code, {FRAC_W{1'b0}}};
    endfunction
endpackage

// File: rtl/saw_trig_sel.sv
module saw_trig_sel #(
    parameter int NUM_EVT = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic               sw_strobe,
    input  logic [NUM_EVT-1:0] hw_evt,
    output logic               fire,
    output logic               reject
);
    logic [NUM_EVT-1:0] evt_q;
    logic [NUM_EVT-1:0] evt_rise;
    logic               hw_hit;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= hw_evt;
    end

    assign evt_rise = hw_evt & ~evt_q;

    always_comb begin
        hw_hit = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (sel == SEL_W'(k + 1)) hw_hit = evt_rise[k];
        end
    end

    assign fire   = (sel == '0) ? sw_strobe : hw_hit;
    assign reject = sw_strobe && (sel != '0);

    // R7: a hardware line held steady under a steady select never triggers
    assert_edge_once_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sel != '0 && $stable(sel) && $stable(hw_evt)) |-> !fire);

    // R8: a refused software strobe never produces a trigger by itself
    assert_sw_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (sel != '0 && sw_strobe && hw_evt == evt_q) |-> !fire);
endmodule

// File: rtl/saw_accum.sv
module saw_accum
    import saw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  saw_fire_t        fire,
    input  saw_cfg_t         cfg,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            if (fire.restart)      acc <= restart_acc(cfg);
            else if (fire.advance) acc <= advance_acc(acc, cfg);
        end
    end

    // R3, R6: restart loads the start code with a zero fraction, even with an advance pending
    assert_restart_load_R3: assert property (@(posedge clk) disable iff (rst)
        (en && fire.restart) |=> (acc[ACC_W-1:FRAC_W] == $past(cfg.start_code)
                                  && acc[FRAC_W-1:0] == '0));

    // R4: upward step
    assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !fire.restart && fire.advance && !cfg.down)
        |=> acc == ACC_W'($past(acc) + $past(cfg.step)));

    // R5: downward step
    assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !fire.restart && fire.advance && cfg.down)
        |=> acc == ACC_W'($past(acc) - $past(cfg.step)));

    // R2: disabled generator holds its state
    assert_hold_off_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));
endmodule

// File: rtl/saw_gen.sv
module saw_gen
    import saw_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         wave_mode,
    input  logic [11:0]        start_code,
    input  logic [15:0]        step_val,
    input  logic               dir_down,
    input  logic [SEL_W-1:0]   restart_sel,
    input  logic [SEL_W-1:0]   advance_sel,
    input  logic               sw_restart,
    input  logic               sw_advance,
    input  logic [NUM_EVT-1:0] hw_evt,
    output logic [11:0]        code_out,
    output logic               err_pulse
);
    wave_mode_e       mode;
    logic             en;
    saw_cfg_t         cfg;
    saw_fire_t        fire;
    logic             rej_restart;
    logic             rej_advance;
    logic [ACC_W-1:0] acc;

    assign mode = wave_mode_e'(wave_mode);
    assign en   = (mode == WM_SAW);

    assign cfg.start_code = start_code;
    assign cfg.step       = step_val;
    assign cfg.down       = dir_down;

    saw_trig_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_restart_src (
        .clk(clk), .rst(rst), .sel(restart_sel), .sw_strobe(sw_restart),
        .hw_evt(hw_evt), .fire(fire.restart), .reject(rej_restart)
    );

    saw_trig_sel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_advance_src (
        .clk(clk), .rst(rst), .sel(advance_sel), .sw_strobe(sw_advance),
        .hw_evt(hw_evt), .fire(fire.advance), .reject(rej_advance)
    );

    saw_accum u_accum (
        .clk(clk), .rst(rst), .en(en), .fire(fire), .cfg(cfg), .acc(acc)
    );

    always_ff @(posedge clk) begin
        if (rst) err_pulse <= 1'b0;
        else     err_pulse <= rej_restart | rej_advance;
    end

    assign code_out = en ? acc[ACC_W-1:FRAC_W] : '0;

    // R8: a strobe on a hardware-routed trigger raises the error next cycle
    assert_err_flag_R8: assert property (@(posedge clk) disable iff (rst)
        ((sw_restart && restart_sel != '0) || (sw_advance && advance_sel != '0)) |=> err_pulse);

    // R8: error only follows a refused strobe
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (!(sw_restart && restart_sel != '0) && !(sw_advance && advance_sel != '0)) |=> !err_pulse);

    // R2: output silent outside sawtooth mode
    assert_code_off_R2: assert property (@(posedge clk) disable iff (rst)
        (wave_mode != 2'b11) |-> code_out == '0);
endmodule

// File: tb/saw_gen_test.sv
module saw_gen_test;
    localparam int NEV = 4;
    localparam int SW  = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     wave_mode = 2'b11;
    logic [11:0]    start_code = '0;
    logic [15:0]    step_val = '0;
    logic           dir_down = 1'b0;
    logic [SW-1:0]  restart_sel = '0;
    logic [SW-1:0]  advance_sel = '0;
    logic           sw_restart = 1'b0;
    logic           sw_advance = 1'b0;
    logic [NEV-1:0] hw_evt = '0;
    logic [11:0]    code_out;
    logic           err_pulse;

    int checks = 0;
    int failures = 0;
    logic [15:0] model = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    saw_gen #(.NUM_EVT(NEV), .SEL_W(SW)) uut (
        .clk(clk), .rst(rst), .wave_mode(wave_mode), .start_code(start_code),
        .step_val(step_val), .dir_down(dir_down), .restart_sel(restart_sel),
        .advance_sel(advance_sel), .sw_restart(sw_restart), .sw_advance(sw_advance),
        .hw_evt(hw_evt), .code_out(code_out), .err_pulse(err_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_code(input string req);
        chk(req, int'(code_out), int'(model[15:4]));
    endtask

    // drive strobes for one cycle, then sample after the edge
    task automatic strobe(input logic r, input logic a);
        @(negedge clk);
        sw_restart = r;
        sw_advance = a;
        @(negedge clk);
        sw_restart = 1'b0;
        sw_advance = 1'b0;
    endtask

    task automatic do_restart();
        strobe(1'b1, 1'b0);
        model = {start_code, 4'h0};
    endtask

    task automatic do_advance();
        strobe(1'b0, 1'b1);
        model = dir_down ? model - step_val : model + step_val;
    endtask

    initial begin
        logic [15:0] steps [7];
        logic [11:0] held;
        steps = '{16'h0001, 16'h0010, 16'h0018, 16'h00FF, 16'h1234, 16'hFFFF, 16'h8000};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code after reset", int'(code_out), 0);
        chk("R1 err after reset", int'(err_pulse), 0);

        // R3 restart load
        start_code = 12'hA5C;
        do_restart();
        chk_code("R3 restart load");

        // R4/R5 sweep over step values and both directions
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 7; s++) begin
                dir_down = d[0];
                step_val = steps[s];
                start_code = 12'h7F0;
                do_restart();
                chk_code("R3 restart before sweep");
                for (int n = 0; n < 20; n++) begin
                    do_advance();
                    chk_code(d == 0 ? "R4 step up" : "R5 step down");
                end
            end
        end

        // R6 restart priority
        dir_down = 1'b0;
        step_val = 16'h0123;
        start_code = 12'h321;
        strobe(1'b1, 1'b1);
        model = {start_code, 4'h0};
        chk_code("R6 restart wins");

        // R2 other modes
        for (int m = 0; m < 3; m++) begin
            wave_mode = m[1:0];
            strobe(1'b0, 1'b1);
            chk("R2 code zero when off", int'(code_out), 0);
            strobe(1'b1, 1'b0);
            chk("R2 code zero when off", int'(code_out), 0);
        end
        wave_mode = 2'b11;
        @(negedge clk);
        chk_code("R2 state kept while off");

        // R8 refused software strobes
        advance_sel = 3'd2;
        held = code_out;
        strobe(1'b0, 1'b1);
        chk("R8 refused advance no effect", int'(code_out), int'(held));
        chk("R8 err pulse", int'(err_pulse), 1);
        @(negedge clk);
        chk("R8 err one cycle", int'(err_pulse), 0);
        restart_sel = 3'd1;
        start_code = 12'hFFF;
        strobe(1'b1, 1'b0);
        chk("R8 refused restart no effect", int'(code_out), int'(held));
        chk("R8 err pulse restart", int'(err_pulse), 1);

        // R7 hardware edges: advance on hw_evt[1]
        @(negedge clk);
        hw_evt[1] = 1'b1;
        @(negedge clk);
        model = model + step_val;
        chk_code("R7 hw edge advance");
        @(negedge clk);
        chk_code("R7 level does not retrigger");
        hw_evt[1] = 1'b0;
        @(negedge clk);

        // R9 restart on hw_evt[0], advance back on software
        advance_sel = 3'd0;
        do_advance();
        chk_code("R9 sw advance with hw restart");
        hw_evt[0] = 1'b1;
        @(negedge clk);
        model = {start_code, 4'h0};
        chk_code("R9 hw restart with sw advance");
        hw_evt[0] = 1'b0;

        // R8/R9 collision: refused restart strobe, hw restart edge, sw advance together
        start_code = 12'h100;
        @(negedge clk);
        sw_restart = 1'b1;
        sw_advance = 1'b1;
        hw_evt[0] = 1'b1;
        @(negedge clk);
        sw_restart = 1'b0;
        sw_advance = 1'b0;
        model = {start_code, 4'h0};
        chk_code("R6 hw restart beats sw advance");
        chk("R8 err during collision", int'(err_pulse), 1);
        hw_evt[0] = 1'b0;

        // R7 highest line and out-of-range select
        advance_sel = 3'd4;
        @(negedge clk);
        hw_evt[3] = 1'b1;
        @(negedge clk);
        model = model + step_val;
        chk_code("R7 event line 3");
        hw_evt = '0;
        advance_sel = 3'd7;
        restart_sel = 3'd5;
        @(negedge clk);
        hw_evt = '1;
        @(negedge clk);
        chk_code("R7 select above range ignored");
        @(negedge clk);
        chk_code("R7 select above range ignored");
        hw_evt = '0;

        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 code after second reset", int'(code_out), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule